// File: doc/BRIEF.md
# Memory Test Access Port with Sample-Only Boundary Register

This block is the serial test port of a memory device. A sixteen-state controller advances on every rising edge of the test clock, steered by the mode-select line. Behind it sit a 3-bit instruction register and three data registers: a 1-bit bypass register, a 32-bit identification register, and a 70-bit boundary register. The boundary register only observes. It takes a snapshot of a parallel bus that carries the current levels of the device pins, and it never drives a pin.

Board test software uses the port to read the device identity and to sample the pins. It can also park the memory's data drivers while it samples. One instruction code samples the pins and also raises a disable output that forces the functional data drivers off. No other instruction affects the functional side. The serial output changes on the falling edge of the test clock. It is enabled only while a register is being shifted.

Top module: `mem_tap`

## Requirements
- R1: The active-low power-on reset `porN` puts the controller in Test-Logic-Reset. Five or more rising test clock edges in a row with `tms` high also put it in Test-Logic-Reset. Four such edges are not enough when they start from Shift-DR.
- R2: The controller follows the standard sixteen-state graph, and each state has one successor for `tms`=0 and one for `tms`=1. Every one of the 32 arcs is reachable.
- R3: The instruction register holds the identification instruction (code 3'b001) after power-on and in Test-Logic-Reset. The shift stage reloads that code in Capture-IR. A newly shifted code takes effect only when the controller leaves Update-IR.
- R4: The active instruction selects the data path. Codes 3'b001 select the identification register. Codes 3'b010 and 3'b100 select the boundary register. Codes 3'b000, 3'b111, 3'b011, 3'b101 and 3'b110 select the bypass register.
- R5: `tdi` is sampled on the rising test clock edge. `tdoData` and `tdoEn` change on the falling edge. `tdoEn` is high only while the controller is in Shift-IR or Shift-DR.
- R6: Each register takes `tdi` into its most significant bit and presents its least significant bit on `tdoData`.
- R7: The bypass register loads 0 in Capture-DR. A bypass scan therefore returns 0 and then the input stream delayed by one cycle.
- R8: The identification register loads {ID_REV, ID_PART, ID_MFR, 1'b1} in Capture-DR. The revision is in bits 31:28, the part number in bits 27:12, the manufacturer code in bits 11:1, and bit 0 is always 1.
- R9: With either sample code active, the boundary register loads `pinState` in Capture-DR. Bit HOLD_POS always reads 0, whatever its pin level.
- R10: `outDisable` is high exactly while the active instruction is 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pinState | input | BSR_LEN | Current pin levels for boundary capture |
| tdoData | output | 1 | Serial data out, updated on falling tck |
| tdoEn | output | 1 | Output enable for tdoData; the pad is high-impedance when low |
| outDisable | output | 1 | Forces the functional data drivers off |

## Verification
The bench keeps the default 70-bit boundary register with its placeholder at bit 53, so a boundary scan covers the full length and shows the forced-zero bit. It overrides the identification fields with distinct, asymmetric values (4'hA, 16'h5C3E, 11'h2B7). A swapped or misplaced field then changes the scanned word. Scans of twice the register length bring the bit order on both ends into view. A long random walk of `tms` reaches all 32 controller arcs.

// File: rtl/memtap_pkg.sv
package memtap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tapState_e;

  localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } drPath_e;

  typedef struct packed {
    logic resetIr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
  } tapStrobe_t;

  // Reserved and bypass codes share the one-bit path.
  function automatic drPath_e decodePath(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:             return PATH_ID;
      OP_SAMPLE_Z, OP_SAMPLE: return PATH_BSR;
      default:               return PATH_BYP;
    endcase
  endfunction

  function automatic tapState_e nextState(tapState_e s, logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

endpackage

// File: rtl/memtap_ctrl.sv
module memtap_ctrl
  import memtap_pkg::*;
(
  input  logic       tck,
  input  logic       porN,
  input  logic       tms,
  output tapState_e  state,
  output tapStrobe_t strobe
);

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) state <= ST_TLR;
    else       state <= nextState(state, tms);
  end

  // Strobes are pure state decodes; the datapath acts on them at the next rising edge.
  always_comb begin
    strobe           = '0;
    strobe.resetIr   = (state == ST_TLR);
    strobe.captureIr = (state == ST_CAP_IR);
    strobe.shiftIr   = (state == ST_SH_IR);
    strobe.updateIr  = (state == ST_UPD_IR);
    strobe.captureDr = (state == ST_CAP_DR);
    strobe.shiftDr   = (state == ST_SH_DR);
  end

endmodule

// File: rtl/memtap_dpath.sv
module memtap_dpath
  import memtap_pkg::*;
#(
  parameter int           BSR_LEN  = 70,
  parameter int           HOLD_POS = 53,
  parameter logic [3:0]   ID_REV   = 4'h3,
  parameter logic [15:0]  ID_PART  = 16'h2C81,
  parameter logic [10:0]  ID_MFR   = 11'h1D5
)(
  input  logic               tck,
  input  logic               porN,
  input  logic               tdi,
  input  tapStrobe_t         strobe,
  input  logic [BSR_LEN-1:0] pinState,
  output logic               tdoData,
  output logic               tdoEn,
  output logic               outDisable,
  output logic [IR_W-1:0]    irActiveOut
);

  localparam int          ID_W     = 32;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_REV, ID_PART, ID_MFR, 1'b1};
  localparam logic [BSR_LEN-1:0] HOLD_MASK = BSR_LEN'(1) << HOLD_POS;

  logic [IR_W-1:0]    irShift;
  logic [IR_W-1:0]    irActive;
  logic               bypassBit;
  logic [ID_W-1:0]    idReg;
  logic [BSR_LEN-1:0] bsrReg;
  logic [BSR_LEN-1:0] capVec;
  drPath_e            curPath;
  logic               drBit;
  logic               serialBit;

  // Per-bit capture cells; the placeholder cell is tied low.
  for (genvar b = 0; b < BSR_LEN; b++) begin : g_cap
    assign capVec[b] = pinState[b] & ~HOLD_MASK[b];
  end

  assign curPath = decodePath(irActive);

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      irShift  <= OP_IDCODE;
      irActive <= OP_IDCODE;
    end else if (strobe.resetIr) begin
      irShift  <= OP_IDCODE;
      irActive <= OP_IDCODE;
    end else begin
      if (strobe.captureIr)    irShift  <= OP_IDCODE;
      else if (strobe.shiftIr) irShift  <= {tdi, irShift[IR_W-1:1]};
      if (strobe.updateIr)     irActive <= irShift;
    end
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      bypassBit <= 1'b0;
      idReg     <= ID_VALUE;
      bsrReg    <= '0;
    end else if (strobe.captureDr) begin
      case (curPath)
        PATH_ID:  idReg     <= ID_VALUE;
        PATH_BSR: bsrReg    <= capVec;
        default:  bypassBit <= 1'b0;
      endcase
    end else if (strobe.shiftDr) begin
      case (curPath)
        PATH_ID:  idReg     <= {tdi, idReg[ID_W-1:1]};
        PATH_BSR: bsrReg    <= {tdi, bsrReg[BSR_LEN-1:1]};
        default:  bypassBit <= tdi;
      endcase
    end
  end

  always_comb begin
    case (curPath)
      PATH_ID:  drBit = idReg[0];
      PATH_BSR: drBit = bsrReg[0];
      default:  drBit = bypassBit;
    endcase
    serialBit = strobe.shiftIr ? irShift[0] : drBit;
  end

  // Serial output retimed to the falling edge.
  always_ff @(negedge tck or negedge porN) begin
    if (!porN) begin
      tdoData <= 1'b0;
      tdoEn   <= 1'b0;
    end else begin
      tdoData <= serialBit;
      tdoEn   <= strobe.shiftIr | strobe.shiftDr;
    end
  end

  assign outDisable  = (irActive == OP_SAMPLE_Z);
  assign irActiveOut = irActive;

endmodule

// File: rtl/mem_tap.sv
module mem_tap
  import memtap_pkg::*;
#(
  parameter int           BSR_LEN  = 70,
  parameter int           HOLD_POS = 53,
  parameter logic [3:0]   ID_REV   = 4'h3,
  parameter logic [15:0]  ID_PART  = 16'h2C81,
  parameter logic [10:0]  ID_MFR   = 11'h1D5
)(
  input  logic               tck,
  input  logic               porN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinState,
  output logic               tdoData,
  output logic               tdoEn,
  output logic               outDisable
);

  tapState_e       curState;
  tapStrobe_t      strobe;
  logic [IR_W-1:0] curIr;

  memtap_ctrl uCtrl (
    .tck    (tck),
    .porN   (porN),
    .tms    (tms),
    .state  (curState),
    .strobe (strobe)
  );

  memtap_dpath #(
    .BSR_LEN  (BSR_LEN),
    .HOLD_POS (HOLD_POS),
    .ID_REV   (ID_REV),
    .ID_PART  (ID_PART),
    .ID_MFR   (ID_MFR)
  ) uDpath (
    .tck         (tck),
    .porN        (porN),
    .tdi         (tdi),
    .strobe      (strobe),
    .pinState    (pinState),
    .tdoData     (tdoData),
    .tdoEn       (tdoEn),
    .outDisable  (outDisable),
    .irActiveOut (curIr)
  );

endmodule

// File: rtl/memtap_chk.sv
module memtap_chk
  import memtap_pkg::*;
(
  input logic            tck,
  input logic            porN,
  input logic            tms,
  input logic            tdoEn,
  input logic            outDisable,
  input tapState_e       curState,
  input logic [IR_W-1:0] curIr
);

  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN)                 onesCnt <= 3'd0;
    else if (!tms)             onesCnt <= 3'd0;
    else if (onesCnt != 3'd7)  onesCnt <= onesCnt + 3'd1;
  end

  p_ones_reset_r1: assert property (@(posedge tck) disable iff (!porN)
    (onesCnt >= 3'd5) |-> (curState == ST_TLR));

  p_capdr_exit_r2: assert property (@(posedge tck) disable iff (!porN)
    (curState == ST_CAP_DR) |=> (curState == ST_SH_DR || curState == ST_EX1_DR));

  p_ir_hold_r3: assert property (@(posedge tck) disable iff (!porN)
    (curState != ST_UPD_IR && curState != ST_TLR) |=> $stable(curIr));

  p_ir_tlr_r3: assert property (@(posedge tck) disable iff (!porN)
    (curState == ST_TLR) |=> (curIr == OP_IDCODE));

  p_tdo_window_r5: assert property (@(posedge tck) disable iff (!porN)
    tdoEn == (curState == ST_SH_IR || curState == ST_SH_DR));

  p_outdis_rise_r10: assert property (@(posedge tck) disable iff (!porN)
    $rose(outDisable) |-> ($past(curState) == ST_UPD_IR));

endmodule

bind mem_tap memtap_chk u_chk (
  .tck        (tck),
  .porN       (porN),
  .tms        (tms),
  .tdoEn      (tdoEn),
  .outDisable (outDisable),
  .curState   (curState),
  .curIr      (curIr)
);

// File: tb/sim_mem_tap.sv
module sim_mem_tap;
  import memtap_pkg::*;

  localparam int          BLEN   = 70;
  localparam int          HPOS   = 53;
  localparam logic [3:0]  T_REV  = 4'hA;
  localparam logic [15:0] T_PART = 16'h5C3E;
  localparam logic [10:0] T_MFR  = 11'h2B7;
  localparam logic [31:0] EXP_ID = {T_REV, T_PART, T_MFR, 1'b1};

  logic tck = 1'b0;
  logic porN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [BLEN-1:0] pins = '0;
  logic tdoData, tdoEn, outDisable;

  mem_tap #(
    .BSR_LEN(BLEN), .HOLD_POS(HPOS),
    .ID_REV(T_REV), .ID_PART(T_PART), .ID_MFR(T_MFR)
  ) u0 (
    .tck(tck), .porN(porN), .tms(tms), .tdi(tdi), .pinState(pins),
    .tdoData(tdoData), .tdoEn(tdoEn), .outDisable(outDisable)
  );

  always #2 tck = ~tck;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  tapState_e   mState;
  logic [2:0]  mIrSh, mIrAct;
  logic        mByp;
  logic [31:0] mId;
  logic [BLEN-1:0] mBsr;
  logic        gotTdo;
  logic [31:0] arcSeen = '0;

  function automatic tapState_e refNext(tapState_e s, logic m);
    case (s)
      ST_TLR:    refNext = m ? ST_TLR    : ST_RTI;
      ST_RTI:    refNext = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: refNext = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: refNext = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  refNext = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: refNext = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: refNext = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: refNext = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: refNext = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: refNext = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: refNext = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  refNext = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: refNext = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: refNext = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: refNext = m ? ST_UPD_IR : ST_SH_IR;
      default:   refNext = m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  // 0 bypass, 1 identification, 2 boundary (R4)
  function automatic int refPath(logic [2:0] op);
    if (op == 3'b001) refPath = 1;
    else if (op == 3'b010 || op == 3'b100) refPath = 2;
    else refPath = 0;
  endfunction

  function automatic logic [BLEN-1:0] refCapture(logic [BLEN-1:0] p);
    logic [BLEN-1:0] r;
    r = p;
    r[HPOS] = 1'b0;
    refCapture = r;
  endfunction

  function automatic logic [BLEN-1:0] randPins();
    logic [95:0] w;
    w = {$urandom, $urandom, $urandom};
    randPins = w[BLEN-1:0];
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [159:0] act, input logic [159:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mState = ST_TLR;
    mIrSh  = 3'b001;
    mIrAct = 3'b001;
    mByp   = 1'b0;
    mId    = EXP_ID;
    mBsr   = '0;
  endtask

  task automatic modelEdge(input logic m, input logic d);
    arcSeen[int'(mState) * 2 + int'(m)] = 1'b1;
    case (mState)
      ST_TLR:    begin mIrSh = 3'b001; mIrAct = 3'b001; end
      ST_CAP_IR: mIrSh = 3'b001;
      ST_SH_IR:  mIrSh = {d, mIrSh[2:1]};
      ST_UPD_IR: mIrAct = mIrSh;
      ST_CAP_DR: begin
        case (refPath(mIrAct))
          1:       mId  = EXP_ID;
          2:       mBsr = refCapture(pins);
          default: mByp = 1'b0;
        endcase
      end
      ST_SH_DR: begin
        case (refPath(mIrAct))
          1:       mId  = {d, mId[31:1]};
          2:       mBsr = {d, mBsr[BLEN-1:1]};
          default: mByp = d;
        endcase
      end
      default: ;
    endcase
    mState = refNext(mState, m);
  endtask

  task automatic step(input logic m, input logic d);
    logic expEn, expBit;
    tms = m;
    tdi = d;
    modelEdge(m, d);
    @(posedge tck);
    @(negedge tck);
    #1;
    gotTdo = tdoData;
    expEn = (mState == ST_SH_IR) || (mState == ST_SH_DR);
    check(tdoEn == expEn, "R5 drive window", 160'(tdoEn), 160'(expEn));
    if (expEn) begin
      if (mState == ST_SH_IR) expBit = mIrSh[0];
      else if (refPath(mIrAct) == 1) expBit = mId[0];
      else if (refPath(mIrAct) == 2) expBit = mBsr[0];
      else expBit = mByp;
      check(tdoData === expBit, "R6 serial bit", 160'(tdoData), 160'(expBit));
    end
    check(outDisable == (mIrAct == 3'b010), "R10 driver disable",
          160'(outDisable), 160'(mIrAct == 3'b010));
  endtask

  task automatic scanDr(input int n, input logic [159:0] din, output logic [159:0] dout);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = gotTdo;
      step(i == n - 1, din[i]);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic scanIr(input logic [2:0] code, output logic [2:0] dout);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      dout[i] = gotTdo;
      step(i == 2, code[i]);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic doReset();
    @(negedge tck); #1;
    porN = 1'b0;
    @(negedge tck); #1;
    modelReset();
    porN = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [159:0] din, dout;
    logic [2:0]   irOut;
    logic [7:0]   exp8;
    void'($urandom(32'd4242));
    modelReset();
    pins = randPins();
    repeat (3) @(negedge tck);
    #1 porN = 1'b1;

    // R1 reset state
    check(tdoEn == 1'b0, "R1 reset tdoEn", 160'(tdoEn), 160'(0));
    check(outDisable == 1'b0, "R1 reset outDisable", 160'(outDisable), 160'(0));
    step(1'b0, 1'b0);

    // R8 identification after reset, R6 order
    din = {$urandom, $urandom, $urandom, $urandom, $urandom};
    scanDr(64, din, dout);
    check(dout[31:0] == EXP_ID, "R8 id readout", 160'(dout[31:0]), 160'(EXP_ID));
    check(dout[0] == 1'b1, "R8 start bit", 160'(dout[0]), 160'(1));
    check(dout[63:32] == din[31:0], "R6 id shift order", 160'(dout[63:32]), 160'(din[31:0]));

    // R3 capture-IR value, R7 bypass
    scanIr(3'b000, irOut);
    check(irOut == 3'b001, "R3 capture ir", 160'(irOut), 160'(3'b001));
    din = {$urandom, $urandom, $urandom, $urandom, $urandom};
    scanDr(16, din, dout);
    check(dout[0] == 1'b0, "R7 bypass zero", 160'(dout[0]), 160'(0));
    check(dout[15:1] == din[14:0], "R7 one-cycle delay", 160'(dout[15:1]), 160'(din[14:0]));

    // R4 decode and R10 disable for every code
    for (int c = 0; c < 8; c++) begin
      logic [2:0] op;
      op = 3'(c);
      pins = randPins();
      scanIr(op, irOut);
      check(outDisable == (op == 3'b010), "R10 per code", 160'(outDisable), 160'(op == 3'b010));
      din = {$urandom, $urandom, $urandom, $urandom, $urandom};
      scanDr(8, din, dout);
      if (refPath(op) == 1) exp8 = EXP_ID[7:0];
      else if (refPath(op) == 2) exp8 = refCapture(pins) & 8'hFF;
      else exp8 = {din[6:0], 1'b0};
      check(dout[7:0] == exp8, "R4 path decode", 160'(dout[7:0]), 160'(exp8));
    end

    // R9 boundary capture under both sample codes
    for (int k = 0; k < 2; k++) begin
      logic [BLEN-1:0] expB;
      scanIr(k == 0 ? 3'b100 : 3'b010, irOut);
      pins = randPins();
      pins[HPOS] = 1'b1;
      din = {$urandom, $urandom, $urandom, $urandom, $urandom};
      scanDr(2 * BLEN, din, dout);
      expB = refCapture(pins);
      check(dout[BLEN-1:0] == expB, "R9 boundary capture", 160'(dout[BLEN-1:0]), 160'(expB));
      check(dout[HPOS] == 1'b0, "R9 placeholder", 160'(dout[HPOS]), 160'(0));
      check(dout[2*BLEN-1:BLEN] == din[BLEN-1:0], "R6 boundary order",
            160'(dout[2*BLEN-1:BLEN]), 160'(din[BLEN-1:0]));
    end

    // R3 new code only takes effect after Update-IR
    scanIr(3'b000, irOut);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(outDisable == 1'b0, "R3 pending code idle", 160'(outDisable), 160'(0));
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    check(outDisable == 1'b0, "R3 in update state", 160'(outDisable), 160'(0));
    step(1'b0, 1'b0);
    check(outDisable == 1'b1, "R3 after update", 160'(outDisable), 160'(1));

    // R1 four high edges from Shift-DR keep state, fifth resets
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    check(outDisable == 1'b1, "R1 four ones", 160'(outDisable), 160'(1));
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check(outDisable == 1'b0, "R1 five ones", 160'(outDisable), 160'(0));
    step(1'b0, 1'b0);
    scanDr(32, '0, dout);
    check(dout[31:0] == EXP_ID, "R1 idcode after ones", 160'(dout[31:0]), 160'(EXP_ID));

    // R1 power-on reset mid-run
    scanIr(3'b010, irOut);
    check(outDisable == 1'b1, "R10 sample-z set", 160'(outDisable), 160'(1));
    doReset();
    #1;
    check(outDisable == 1'b0, "R1 por outDisable", 160'(outDisable), 160'(0));
    check(tdoEn == 1'b0, "R1 por tdoEn", 160'(tdoEn), 160'(0));
    step(1'b0, 1'b0);

    // R2 random walk over the graph
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 49) == 0) pins = randPins();
      step($urandom_range(0, 99) < 45, 1'($urandom));
    end
    check(arcSeen == 32'hFFFF_FFFF, "R2 all arcs", 160'(arcSeen), 160'(32'hFFFF_FFFF));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule